// File: doc/BRIEF.md
# Prioritized Interrupt Jump-Table Vector Register

This block is a 16-bit bus register that gives software a ready-made branch target for conversion-complete handling. Software writes the base address of a jump table into it. Seven pair-ready inputs come from the converter, one for each input pair. A read then does not return the stored base. It returns the base plus four times the number of the most urgent ready pair, which is the address of that pair's four-byte table slot. Ready line 0 wins over all the others and line 6 loses to all of them. A handler can branch through the value it reads without any search loop in software.

The bus is a plain synchronous register port with an address, a write strobe, write data, a read strobe and read data. The read result is registered. It appears on the clock after the read strobe and is built from the ready lines as they stood on the strobe cycle. It stays put until the next read strobe.

Top module: `jtv_vector_reg`

## Requirements
- R1: After a synchronous active-low reset the stored base is zero and `bus_rdata` is zero, so a read with no ready line set returns 0x0000.
- R2: A write with `bus_wr_en` high and `bus_addr` equal to `REG_ADDR` (default 4'h3) stores `bus_wdata[15:1]`; `bus_wdata[0]` is discarded and the base's bit 0 is always zero.
- R3: A write to any other address leaves the stored base unchanged, as seen on a following read.
- R4: The selected index is the lowest-numbered asserted bit of `pair_ready` (bit 0 highest priority, bit 6 lowest); higher-numbered set bits are ignored.
- R5: A read at `REG_ADDR` returns base + (index << 2), so the added term has its two low bits zero.
- R6: With `pair_ready` all zero, a read at `REG_ADDR` returns the stored base unchanged.
- R7: The sum is taken modulo 2^16; a carry out of bit 15 is dropped.
- R8: `bus_rdata` changes only on the clock edge that samples `bus_rd_en` high, using `pair_ready` from that cycle, and holds its value on cycles with no read strobe.
- R9: A read strobe at any address other than `REG_ADDR` loads 0x0000 into `bus_rdata`.
- R10: When a write and a read to `REG_ADDR` fall in the same cycle, the read returns the base held before that write, and the new base shows on later reads.
- R11: Bit 0 of `bus_rdata` is always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read result, valid the clock after the strobe |
| pair_ready | input | 7 | Per-pair conversion-ready lines, bit 0 most urgent |

## Verification
Two functions can fall in one clock edge: a base update from a write, and a vector read that adds the encoded index to the base. The bench raises both strobes on the same cycle with a fresh write value and a nonzero ready pattern. It expects the old base plus the scaled index on that read, and the new base on the next read. A second collision happens between the registered read and the ready lines. The bench changes `pair_ready` on the cycle right after a strobe and checks that the result still reflects the strobe-cycle pattern.

// File: rtl/jtv_pkg.sv
// Package: shared constants for the jump-table vector register.
// Assumes: a byte-addressed table whose entries are four bytes apart.
package jtv_pkg;
    localparam int JTV_DATA_W    = 16;
    localparam int JTV_FLAGS     = 7;
    localparam int JTV_IDX_SHIFT = 2;
    localparam int JTV_ADDR_W    = 4;
endpackage

// File: rtl/jtv_base_store.sv
// Module: holds the table base address written over the register bus.
// Assumes: the decode of the register address is done by the parent; bit 0
// of the base never stores a one.
module jtv_base_store #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] base_q
);
    // Load the upper bits on an addressed write, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= '0;
        else if (wr_hit)
            base_q <= {wdata[DATA_W-1:1], 1'b0};
    end

    // R3: without an addressed write the base must not move.
    p_base_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(base_q));
    // R2: the stored base has no bit 0 after a write.
    p_base_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (base_q[0] == 1'b0));
endmodule

// File: rtl/jtv_prio_enc.sv
// Module: fixed-priority encoder over the ready lines; line 0 wins.
// Assumes: the request vector is at least two bits wide.
module jtv_prio_enc #(
    parameter int N     = 7,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    logic [N-1:0] gnt;

    // One grant per line: set only when no lower-numbered line requests.
    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_grant
            if (gi == 0) begin : g_top
                assign gnt[gi] = req[gi];
            end else begin : g_rest
                assign gnt[gi] = req[gi] & ~(|req[gi-1:0]);
            end
        end
    endgenerate

    // Turn the one-hot grant into its bit number.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt[i])
                idx = idx | IDX_W'(i);
        end
    end

    assign any = |req;

    // R4: a single winner whenever a line requests, none otherwise.
    p_single_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        any |-> ($countones(gnt) == 1));
    p_no_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !any |-> (gnt == '0));
endmodule

// File: rtl/jtv_vector_sum.sv
// Module: scales the winning index, adds it to the base and registers the
// read result.
// Assumes: the strobe and hit are qualified by the parent; the sum wraps.
module jtv_vector_sum #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 3,
    parameter int SHIFT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              rd_hit,
    input  logic [DATA_W-1:0] base_q,
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] term;
    logic [DATA_W-1:0] sum;

    // Scale the index to a table-entry offset and add, dropping the carry.
    always_comb begin
        term = DATA_W'(idx) << SHIFT;
        sum  = base_q + term;
    end

    // Capture the vector on an addressed read; zero on a stray read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en && rd_hit)
            rdata <= {sum[DATA_W-1:1], 1'b0};
        else if (rd_en)
            rdata <= '0;
    end

    // R8: no strobe, no change.
    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
    // R9: a read at another address returns zero.
    p_stray_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_hit) |=> (rdata == '0));
    // R11: the result is always even.
    p_rdata_even_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[0] == 1'b0);
endmodule

// File: rtl/jtv_vector_reg.sv
// Module: top of the jump-table vector register: base storage, priority
// encoder and scaled adder behind a simple synchronous register port.
// Assumes: one register address; read data valid one clock after strobe.
module jtv_vector_reg
    import jtv_pkg::*;
#(
    parameter int                  DATA_W    = JTV_DATA_W,
    parameter int                  FLAGS     = JTV_FLAGS,
    parameter int                  IDX_SHIFT = JTV_IDX_SHIFT,
    parameter int                  ADDR_W    = JTV_ADDR_W,
    parameter logic [ADDR_W-1:0]   REG_ADDR  = 4'h3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd_en,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [FLAGS-1:0]  pair_ready
);
    localparam int IDX_W = $clog2(FLAGS);

    logic              addr_hit;
    logic              wr_hit;
    logic [DATA_W-1:0] base_q;
    logic [IDX_W-1:0]  win_idx;
    logic              any_ready;

    // Decode the single register address.
    always_comb begin
        addr_hit = (bus_addr == REG_ADDR);
        wr_hit   = bus_wr_en && addr_hit;
    end

    jtv_base_store #(.DATA_W(DATA_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (wr_hit),
        .wdata  (bus_wdata),
        .base_q (base_q)
    );

    jtv_prio_enc #(.N(FLAGS), .IDX_W(IDX_W)) u_enc (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (pair_ready),
        .idx   (win_idx),
        .any   (any_ready)
    );

    jtv_vector_sum #(.DATA_W(DATA_W), .IDX_W(IDX_W), .SHIFT(IDX_SHIFT)) u_sum (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (bus_rd_en),
        .rd_hit (addr_hit),
        .base_q (base_q),
        .idx    (win_idx),
        .rdata  (bus_rdata)
    );

    // R6: with nothing ready an addressed read returns the base as held.
    p_idle_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && addr_hit && !any_ready) |=> (bus_rdata == $past(base_q)));
    // R10: a same-cycle write does not leak into the read it collides with.
    p_collide_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && wr_hit && !any_ready) |=> (bus_rdata == $past(base_q)));
endmodule

// File: tb/jtv_vector_reg_tb.sv
// Bench: scoreboard for the jump-table vector register. Driver tasks push
// expected read results; a monitor pops and compares after each strobe.
module jtv_vector_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        bus_rd_en = 1'b0;
    logic [15:0] bus_rdata;
    logic [6:0]  pair_ready = '0;

    int checks = 0;
    int failures = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] model_base = '0;

    localparam logic [3:0] A_REG = 4'h3;

    always #2 clk = ~clk;

    jtv_vector_reg dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
        .pair_ready(pair_ready)
    );

    function automatic logic [15:0] vec(input logic [15:0] b, input logic [6:0] f);
        int k = 0;
        for (int i = 6; i >= 0; i--) if (f[i]) k = i;
        return (b & 16'hFFFE) + 16'(k * 4);
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        bus_wr_en = 1'b0; bus_rd_en = 1'b0;
    endtask

    task automatic do_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1; bus_rd_en = 1'b0;
        if (a == A_REG) model_base = d & 16'hFFFE;
    endtask

    task automatic do_read(input logic [3:0] a, input logic [6:0] f, input string tag);
        @(negedge clk);
        bus_addr = a; pair_ready = f; bus_wr_en = 1'b0; bus_rd_en = 1'b1;
        exp_q.push_back(a == A_REG ? vec(model_base, f) : 16'h0000);
        tag_q.push_back(tag);
    endtask

    task automatic do_both(input logic [15:0] d, input logic [6:0] f);
        @(negedge clk);
        bus_addr = A_REG; pair_ready = f; bus_wdata = d;
        bus_wr_en = 1'b1; bus_rd_en = 1'b1;
        exp_q.push_back(vec(model_base, f));
        tag_q.push_back("R10");
        model_base = d & 16'hFFFE;
    endtask

    // Monitor: after each sampled strobe, compare the registered result.
    always @(posedge clk) begin
        if (rst_n && bus_rd_en) begin
            #1;
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R8 actual=%h expected=<none>", bus_rdata);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
                check("R11", {15'h0, bus_rdata[0]}, 16'h0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        check("R1", bus_rdata, 16'h0000);
        do_read(A_REG, 7'h00, "R1");
        // R2: bit 0 of write data dropped
        do_write(A_REG, 16'h1235);
        do_read(A_REG, 7'h00, "R2");
        // R3: foreign write leaves base alone
        do_write(4'h5, 16'hBEEF);
        do_read(A_REG, 7'h00, "R3");
        // R4/R5: every pattern with random bases
        for (int f = 0; f < 128; f++) begin
            do_write(A_REG, 16'($urandom));
            do_read(A_REG, 7'(f), f == 0 ? "R6" : "R4_R5");
        end
        // R4: only the lowest set line counts
        do_write(A_REG, 16'h0100);
        do_read(A_REG, 7'h7F, "R4");
        do_read(A_REG, 7'h40, "R5");
        // R7: wrap past 16 bits
        do_write(A_REG, 16'hFFFE);
        do_read(A_REG, 7'h40, "R7");
        // R9: read at another address
        do_read(4'h0, 7'h01, "R9");
        // R10: write and read in the same cycle
        do_write(A_REG, 16'h2000);
        do_both(16'h4000, 7'h08);
        do_read(A_REG, 7'h00, "R10");
        // R8: ready lines change after strobe; value then holds
        do_read(A_REG, 7'h04, "R8");
        @(negedge clk);
        bus_rd_en = 1'b0; pair_ready = 7'h01;
        @(negedge clk);
        held = bus_rdata;
        check("R8", held, 16'h4008);
        repeat (3) @(negedge clk);
        check("R8", bus_rdata, held);
        idle();
        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; failures++;
            $display("FAIL R8 actual=%0d expected=0 pending", exp_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule